// File: doc/BRIEF.md
# Frame-Locked Converter Stimulus and Capture Sequencer

This block drives a data converter under test and records what the converter returns, using one repeating sampling frame of a fixed number of master clocks. On the first clock of every frame it raises a one-clock frame-sync pulse and places the next stimulus word from an internal source memory on a parallel output bus. At a programmable clock offset inside the same frame it stores the word on a parallel input bus into an internal capture memory. Stimulus and capture share one frame counter, so their sample rates stay locked to each other.

Before a run, software-side logic fills the source memory through a valid/ready load port. The load port is ready only while no run is active. A load word is taken on a clock edge where both valid and ready are high, and valid may be held high across a busy period without loss. A start pulse takes a snapshot of the sample count, the frame count and the capture offset, then runs that many frames. The done flag marks the end of the run. Captured words are read back through a plain address/data port with one clock of latency.

Top module: `frame_sample_sequencer`

## Requirements
- R1: While a run is active, `fsync` is high for exactly one clock at the start of each frame. Frames are 16 clocks long, so consecutive pulses are 16 clocks apart, and a run of F frames gives exactly F pulses.
- R2: `dac_data` takes its new word in the same clock in which `fsync` is high. It holds that word through the rest of the frame.
- R3: The sample for frame k of a run is source location k mod N, where N is the snapshot sample count (1 to 256). The first frame therefore uses location 0, and the sequence wraps to 0 after location N-1.
- R4: Phase 0 is the clock in which `fsync` is high. In each frame, the word on `adc_data` during the clock at phase P (the snapshot capture offset, 0 to 15) is stored into consecutive capture locations starting at 0. The input bus has no effect at any other phase. Storing stops after N words.
- R5: A run lasts F frames (F from 1 to 65535). `busy` falls and `done` rises in the clock that follows the capture clock of the last frame. `done` stays high until the next accepted start.
- R6: A start pulse while `busy` is high is ignored. The frame sequence and the frame count continue unchanged.
- R7: A synchronous active-high reset clears `busy`, `done` and `fsync`, drives `dac_data` to 0, and clears the addresses and the frame counter.
- R8: `ld_ready` is high exactly when `busy` is low. A load word is written to location `ld_addr` only on an edge where both `ld_valid` and `ld_ready` are high. Words offered during a run are not written.
- R9: `rd_data` shows capture location `rd_addr` one clock after the address is applied.
- R10: Changes to `cfg_samples`, `cfg_frames` or `cfg_cap_phase` during a run have no effect on that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a run when idle |
| cfg_samples | input | 9 | Sample count N, 1..256 |
| cfg_frames | input | 16 | Frames per run F, 1..65535 |
| cfg_cap_phase | input | 4 | Capture offset P within the frame |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run has finished |
| fsync | output | 1 | Frame-sync pulse |
| dac_data | output | 8 | Stimulus word to the converter |
| adc_data | input | 8 | Word returned by the converter |
| ld_valid | input | 1 | Load word offered |
| ld_ready | output | 1 | Load word can be accepted |
| ld_addr | input | 8 | Source memory location of load word |
| ld_data | input | 8 | Load word |
| rd_addr | input | 8 | Capture memory read location |
| rd_data | output | 8 | Capture word, one clock after address |

## Verification
An accepted start makes `busy`, `fsync` and the first stimulus word visible in the very next clock. The input word at phase P is stored on the edge that closes that clock, and `done` appears one clock after the final such edge. Read data trails its address by one clock. The bench keeps a behavioural model that advances on each rising edge from the same inputs, and it compares every output at the falling edge. Each expected value is therefore taken in exactly the clock the rules above assign to it.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
  parameter int SAMPLE_W  = 8;
  parameter int MEM_DEPTH = 256;
  parameter int FRAME_LEN = 16;
  parameter int FRAMES_W  = 16;

  localparam int ADDR_W  = $clog2(MEM_DEPTH);
  localparam int CNT_W   = ADDR_W + 1;
  localparam int PHASE_W = $clog2(FRAME_LEN);

  typedef logic [SAMPLE_W-1:0] sample_t;
  typedef logic [ADDR_W-1:0]   addr_t;
  typedef logic [CNT_W-1:0]    count_t;
  typedef logic [PHASE_W-1:0]  phase_t;
  typedef logic [FRAMES_W-1:0] frames_t;

  typedef struct packed {
    count_t  samples;
    frames_t frames;
    phase_t  cap_phase;
  } run_cfg_t;
endpackage

// File: rtl/fseq_frame_timer.sv
module fseq_frame_timer
  import fseq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   run,
  input  logic   clear,
  output phase_t phase,
  output logic   at_last,
  output logic   fsync
);
  localparam phase_t LAST = phase_t'(FRAME_LEN - 1);
  localparam bit POW2 = (FRAME_LEN == (1 << PHASE_W));

  phase_t phase_q;
  phase_t phase_nx;

  generate
    if (POW2) begin : g_natural_wrap
      always_comb phase_nx = phase_q + 1'b1;
    end else begin : g_compare_wrap
      always_comb phase_nx = (phase_q == LAST) ? '0 : phase_q + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clear) phase_q <= '0;
    else if (run)     phase_q <= phase_nx;
  end

  assign phase   = phase_q;
  assign at_last = (phase_q == LAST);
  assign fsync   = run && (phase_q == '0);

  // R1: one frame ends, the next begins at phase 0
  a_r1_phase_wrap: assert property (@(posedge clk) disable iff (rst)
    (run && !clear && phase_q == LAST) |=> (phase_q == '0));
  // R1: the sync pulse is a single clock wide
  a_r1_fsync_single: assert property (@(posedge clk) disable iff (rst)
    fsync |=> !fsync);
endmodule

// File: rtl/fseq_src_mem.sv
module fseq_src_mem
  import fseq_pkg::*;
(
  input  logic    clk,
  input  logic    we,
  input  addr_t   waddr,
  input  sample_t wdata,
  input  addr_t   raddr,
  output sample_t rdata
);
  sample_t mem [MEM_DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/fseq_cap_mem.sv
module fseq_cap_mem
  import fseq_pkg::*;
(
  input  logic    clk,
  input  logic    we,
  input  addr_t   waddr,
  input  sample_t wdata,
  input  addr_t   raddr,
  output sample_t rdata
);
  sample_t mem [MEM_DEPTH];
  sample_t rdata_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata_q <= mem[raddr];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/frame_sample_sequencer.sv
module frame_sample_sequencer
  import fseq_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [CNT_W-1:0]    cfg_samples,
  input  logic [FRAMES_W-1:0] cfg_frames,
  input  logic [PHASE_W-1:0]  cfg_cap_phase,
  output logic                busy,
  output logic                done,
  output logic                fsync,
  output logic [SAMPLE_W-1:0] dac_data,
  input  logic [SAMPLE_W-1:0] adc_data,
  input  logic                ld_valid,
  output logic                ld_ready,
  input  logic [ADDR_W-1:0]   ld_addr,
  input  logic [SAMPLE_W-1:0] ld_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [SAMPLE_W-1:0] rd_data
);
  logic     busy_q, done_q;
  run_cfg_t cfg_q;
  frames_t  frame_idx_q;
  addr_t    src_addr_q;
  count_t   cap_cnt_q;
  sample_t  dac_q;

  phase_t   phase;
  logic     at_last;
  logic     start_acc, cap_hit, last_frame, run_end, frame_adv, cap_we;
  addr_t    src_raddr, src_next;
  sample_t  src_word;

  assign start_acc  = start && !busy_q;
  assign cap_hit    = busy_q && (phase == cfg_q.cap_phase);
  assign last_frame = (frame_idx_q == cfg_q.frames - 1'b1);
  assign run_end    = cap_hit && last_frame;
  assign frame_adv  = busy_q && at_last && !run_end;
  assign cap_we     = cap_hit && (cap_cnt_q < cfg_q.samples);
  assign src_raddr  = start_acc ? '0 : src_addr_q;
  assign src_next   = ({1'b0, src_addr_q} == cfg_q.samples - 1'b1) ? '0 : src_addr_q + 1'b1;

  fseq_frame_timer i_timer (
    .clk(clk), .rst(rst), .run(busy_q), .clear(start_acc),
    .phase(phase), .at_last(at_last), .fsync(fsync)
  );

  fseq_src_mem i_src (
    .clk(clk), .we(ld_valid && !busy_q), .waddr(ld_addr), .wdata(ld_data),
    .raddr(src_raddr), .rdata(src_word)
  );

  fseq_cap_mem i_cap (
    .clk(clk), .we(cap_we), .waddr(cap_cnt_q[ADDR_W-1:0]), .wdata(adc_data),
    .raddr(rd_addr), .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q      <= 1'b0;
      done_q      <= 1'b0;
      cfg_q       <= '{samples: count_t'(1), frames: frames_t'(1), cap_phase: phase_t'(FRAME_LEN / 2)};
      frame_idx_q <= '0;
      src_addr_q  <= '0;
      cap_cnt_q   <= '0;
      dac_q       <= '0;
    end else if (start_acc) begin
      busy_q      <= 1'b1;
      done_q      <= 1'b0;
      cfg_q       <= '{samples: cfg_samples, frames: cfg_frames, cap_phase: cfg_cap_phase};
      frame_idx_q <= '0;
      src_addr_q  <= (cfg_samples == count_t'(1)) ? '0 : addr_t'(1);
      cap_cnt_q   <= '0;
      dac_q       <= src_word;
    end else if (busy_q) begin
      if (cap_we) cap_cnt_q <= cap_cnt_q + 1'b1;
      if (run_end) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
      if (frame_adv) begin
        frame_idx_q <= frame_idx_q + 1'b1;
        dac_q       <= src_word;
        src_addr_q  <= src_next;
      end
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign dac_data = dac_q;
  assign ld_ready = !busy_q;

  // R2: stimulus word steady between sync pulses
  a_r2_dac_hold: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !fsync) |-> $stable(dac_data));
  // R3: source address stays inside the sample window
  a_r3_src_in_window: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> ({1'b0, src_addr_q} < cfg_q.samples));
  // R4: never more stores than the sample count
  a_r4_cap_bound: assert property (@(posedge clk) disable iff (rst)
    cap_cnt_q <= cfg_q.samples);
  // R5: done appears only as the run closes
  a_r5_done_at_end: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $fell(busy));
  // R6: a start during a run does not disturb the frame count
  a_r6_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy_q && start && !run_end) |=> (fsync || frame_idx_q == $past(frame_idx_q)));
  // R10: snapshot settings stay fixed during a run
  a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
    (busy_q && $past(busy_q)) |-> $stable(cfg_q));
endmodule

// File: tb/test_frame_sample_sequencer.sv
module test_frame_sample_sequencer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [8:0] cfg_samples = 9'd1;
  logic [15:0] cfg_frames = 16'd1;
  logic [3:0] cfg_cap_phase = 4'd8;
  logic       busy, done, fsync, ld_ready;
  logic [7:0] dac_data, rd_data;
  logic [7:0] adc_data = 8'd0;
  logic       ld_valid = 1'b0;
  logic [7:0] ld_addr = 8'd0, ld_data = 8'd0, rd_addr = 8'd0;

  int checks = 0, errors = 0, cyc = 0, fs_count = 0;
  bit finished = 0;

  // behavioural model
  int m_src[256];
  int m_cap[256];
  bit m_capw[256];
  bit m_busy = 0, m_done = 0, m_rd_known = 0;
  int m_phase = 0, m_frame = 0, m_srcidx = 0, m_capidx = 0, m_dac = 0, m_rd = 0;
  int m_n = 1, m_f = 1, m_cp = 8;

  frame_sample_sequencer i_frame_sample_sequencer (
    .clk(clk), .rst(rst), .start(start), .cfg_samples(cfg_samples),
    .cfg_frames(cfg_frames), .cfg_cap_phase(cfg_cap_phase), .busy(busy),
    .done(done), .fsync(fsync), .dac_data(dac_data), .adc_data(adc_data),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr),
    .ld_data(ld_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_busy = 0; m_done = 0; m_phase = 0; m_frame = 0;
      m_srcidx = 0; m_capidx = 0; m_dac = 0; m_rd_known = 0;
    end else begin
      m_rd_known = m_capw[rd_addr];
      m_rd = m_cap[rd_addr];
      if (m_busy) begin
        if (m_phase == m_cp) begin
          if (m_capidx < m_n) begin
            m_cap[m_capidx] = int'(adc_data);
            m_capw[m_capidx] = 1;
            m_capidx++;
          end
          if (m_frame == m_f - 1) begin
            m_busy = 0;
            m_done = 1;
          end
        end
        if (m_busy) begin
          if (m_phase == 15) begin
            m_phase = 0;
            m_frame++;
            m_dac = m_src[m_srcidx];
            m_srcidx = (m_srcidx + 1) % m_n;
          end else m_phase++;
        end else m_phase = (m_phase + 1) % 16;
      end else begin
        if (start) begin
          m_busy = 1; m_done = 0; m_phase = 0; m_frame = 0;
          m_n = int'(cfg_samples); m_f = int'(cfg_frames); m_cp = int'(cfg_cap_phase);
          m_dac = m_src[0];
          m_srcidx = 1 % m_n;
          m_capidx = 0;
        end
        if (ld_valid) m_src[ld_addr] = int'(ld_data);
      end
    end
  end

  // compare on the falling edge, then move the input stimulus
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(fsync == (m_busy && m_phase == 0), "R1 fsync", fsync, m_busy && m_phase == 0);
      chk(int'(dac_data) == m_dac, "R2/R3 dac_data", dac_data, m_dac);
      chk(done == m_done, "R5 done", done, m_done);
      chk(busy == m_busy, "R5/R6 busy", busy, m_busy);
      chk(ld_ready == !m_busy, "R8 ld_ready", ld_ready, !m_busy);
      if (m_rd_known) chk(int'(rd_data) == m_rd, "R4/R9 rd_data", rd_data, m_rd);
      if (fsync) fs_count++;
    end
    adc_data <= 8'(cyc * 37 + 11);
  end

  always @(posedge clk) begin
    if (cyc > 100000 && !finished) begin
      errors++;
      $display("FAIL R5 watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic load(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ld_valid = 1; ld_addr = 8'(i); ld_data = 8'((i * seed + 5) ^ 8'h5A);
    end
    @(negedge clk);
    ld_valid = 0;
  endtask

  task automatic run(input int n, input int f, input int cp, input bit poke);
    @(negedge clk);
    cfg_samples = 9'(n); cfg_frames = 16'(f); cfg_cap_phase = 4'(cp);
    start = 1;
    fs_count = 0;
    @(negedge clk);
    start = 0;
    if (poke) begin
      repeat (18) @(negedge clk);
      start = 1;                           // R6 ignored start
      cfg_samples = 9'd3; cfg_frames = 16'd2; cfg_cap_phase = 4'd1; // R10
      ld_valid = 1; ld_addr = 8'd0; ld_data = 8'hEE;                 // R8 refused
      @(negedge clk);
      start = 0; ld_valid = 0;
    end
    for (int k = 0; k < 5000 && !done; k++) @(negedge clk);
    chk(done == 1'b1, "R5 done after run", done, 1);
    chk(fs_count == f, "R1 sync pulse count", fs_count, f);
  endtask

  task automatic readback(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rd_addr = 8'(i);
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin m_src[i] = 0; m_cap[i] = 0; m_capw[i] = 0; end
    repeat (3) @(negedge clk);
    // R7 reset state
    chk(dac_data == 8'd0, "R7 dac reset", dac_data, 0);
    chk(busy == 1'b0 && done == 1'b0 && fsync == 1'b0, "R7 flags reset", {busy, done, fsync}, 0);
    rst = 0;
    load(5, 3);
    // R3 wrap, R4 stop after N, R6/R8/R10 during run
    run(5, 12, 8, 1);
    chk(m_capidx == 5, "R4 store count", m_capidx, 5);
    readback(7);
    // first source location was refused during the run (R8)
    chk(m_src[0] != 32'hEE, "R8 refused load", m_src[0], 0);
    load(256, 7);
    run(256, 3, 15, 0);                     // last phase capture
    readback(4);
    run(1, 4, 0, 0);                        // single-sample wrap, phase 0 capture
    readback(2);
    run(2, 1, 3, 0);                        // one-frame run
    readback(2);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule